// File: doc/BRIEF.md
# Address Region Decoder with Boot Remap and Abort

This block sorts every access on a 32-bit system address into one of three regions: on-chip RAM in the bottom 4 MB, on-chip peripherals in the top 4 MB, and the external-bus window between them. The external window holds up to eight chip-select banks. Each bank takes a base (in 16 MB units), a size code and an enable from configuration inputs. An access that lands in the window but matches no usable bank raises an abort. Accesses to RAM or to peripherals never abort.

A sticky remap flag decides what sits at the bottom of the map. Before remap, the bottom 4 MB reaches boot memory on chip select 0, and banks 1 and up cannot be selected. After a single remap request, the bottom 4 MB is on-chip RAM and every enabled bank can be selected. Only reset clears the flag. Peripheral accesses are forced to word alignment, and they report which 16 KB peripheral slot they hit. The top slot belongs to the interrupt controller and is only 4 KB deep, so addresses inside it alias modulo 4 KB.

Each decoded result is registered and appears one clock after the request.

Top module: `addr_region_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rsp_valid`, `rsp_region`, `rsp_cs`, `rsp_abort`, `rsp_addr`, `rsp_slot` and `remap_active` are all zero.
- R2: With remap active, an address whose bits 31:22 are all zero decodes to region code 3'b001 (on-chip RAM), with no chip select and no abort.
- R3: With remap inactive, an address whose bits 31:22 are all zero decodes to region code 3'b010 (external), with `rsp_cs` equal to 8'b0000_0001 and no abort.
- R4: An address whose bits 31:22 are all ones decodes to region code 3'b100 (peripheral), with no chip select and no abort. `rsp_addr` equals the request with bits 1:0 cleared, and `rsp_slot` equals address bits 21:14.
- R5: In peripheral slot 8'hFF, `rsp_addr` additionally has bits 13:12 cleared, so the slot aliases every 4 KB.
- R6: In the external window, bank i matches when it is enabled and address bits 31:24 equal its base. The chosen chip select is the lowest-indexed usable matching bank, and `rsp_cs` is one-hot for that bank.
- R7: While remap is inactive, banks 1 to 7 are unusable, so a window access that matches only those banks aborts. Bank 0 remains usable.
- R8: A window access with no usable matching bank gives region 3'b010, `rsp_abort` high and `rsp_cs` zero.
- R9: A one-cycle `remap_req` sets `remap_active` from the next cycle onward. Further requests have no effect, and only reset clears the flag.
- R10: The 3-bit size code k of a bank covers (1 MB << k) from the bank base, which means address bits 23:20 must be below 2^k. Codes 4 to 7 cover the full 16 MB.
- R11: A request with `req_valid` high gives `rsp_valid` high exactly one cycle later, with exactly one region bit set. With no request, the next cycle has `rsp_valid`, region and chip select all zero.
- R12: For non-peripheral accesses, `rsp_addr` equals the request address unchanged, and `rsp_slot` is zero.
- R13: An access presented in the same cycle as `remap_req` is decoded with the mapping that held before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the remap flag and the outputs |
| remap_req | input | 1 | One-cycle request that sets the sticky remap flag |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 32 | Access address |
| cfg_bank_en | input | 8 | Per-bank enable |
| cfg_bank_base | input | 64 | Per-bank base, 8 bits each (address bits 31:24), bank i at [8i+7:8i] |
| cfg_bank_size | input | 24 | Per-bank size code, 3 bits each, bank i at [3i+2:3i] |
| remap_active | output | 1 | Remap flag state |
| rsp_valid | output | 1 | Decoded result valid |
| rsp_region | output | 3 | One-hot region: 001 RAM, 010 external, 100 peripheral |
| rsp_cs | output | 8 | One-hot chip select, zero if none |
| rsp_abort | output | 1 | Undefined external address |
| rsp_addr | output | 32 | Address after alignment and aliasing |
| rsp_slot | output | 8 | Peripheral slot index, zero outside peripherals |

## Verification
The delicate overlap is a remap request arriving in the same cycle as an access to the bottom of the map, or to a bank above 0. The access must resolve with the old mapping, and the flag changes only afterwards. The bench issues `remap_req` together with a bottom-4 MB access. It expects chip select 0 for that access, then RAM on the very next access, and it checks `remap_active` on every response. Random traffic that concentrates on bank bases, including overlapping banks of differing sizes, shows gating and priority together. Every response is compared against a reference model that tracks the flag itself.

// File: rtl/adec_pkg.sv
package adec_pkg;
   typedef enum logic [2:0] {
      RGN_NONE   = 3'b000,
      RGN_IRAM   = 3'b001,
      RGN_EXT    = 3'b010,
      RGN_PERIPH = 3'b100
   } region_e;
endpackage

// File: rtl/adec_region_sort.sv
// Classifies an address as bottom window, top window or external window.
module adec_region_sort #(
   parameter int ADDR_W      = 32,
   parameter int REGION_LOG2 = 22
) (
   input  logic [ADDR_W-REGION_LOG2-1:0] addr_hi,
   output logic                          is_low,
   output logic                          is_high,
   output logic                          is_window
);
   always_comb begin
      is_low    = (addr_hi == '0);
      is_high   = (addr_hi == '1);
      is_window = !is_low && !is_high;
   end
endmodule

// File: rtl/adec_bank_match.sv
// One chip-select bank: base compare plus power-of-two size window.
module adec_bank_match #(
   parameter int BASE_W = 8,
   parameter int OFF_W  = 4,
   parameter int SIZE_W = 3
) (
   input  logic [BASE_W-1:0] addr_base,
   input  logic [OFF_W-1:0]  addr_off,
   input  logic [BASE_W-1:0] cfg_base,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic              cfg_en,
   output logic              hit
);
   logic             in_size;
   logic [OFF_W-1:0] shifted;

   always_comb begin
      shifted = addr_off >> cfg_size;
      if (int'(cfg_size) >= OFF_W) in_size = 1'b1;
      else                         in_size = (shifted == '0);
      hit = cfg_en && (addr_base == cfg_base) && in_size;
   end
endmodule

// File: rtl/adec_pick_first.sv
// Lowest-index one-hot selection.
module adec_pick_first #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/adec_remap_reg.sv
// Sticky remap flag, cleared only by reset.
module adec_remap_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_q | set_req;
   end
endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder #(
   parameter int ADDR_W      = 32,
   parameter int NCS         = 8,
   parameter int REGION_LOG2 = 22,
   parameter int BANK_LOG2   = 24,
   parameter int UNIT_LOG2   = 20,
   parameter int SIZE_W      = 3,
   parameter int SLOT_LOG2   = 14,
   parameter int INTC_LOG2   = 12,
   parameter int ALIGN_LOG2  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       remap_req,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [NCS-1:0]             cfg_bank_en,
   input  logic [NCS*(ADDR_W-BANK_LOG2)-1:0] cfg_bank_base,
   input  logic [NCS*SIZE_W-1:0]      cfg_bank_size,
   output logic                       remap_active,
   output logic                       rsp_valid,
   output logic [2:0]                 rsp_region,
   output logic [NCS-1:0]             rsp_cs,
   output logic                       rsp_abort,
   output logic [ADDR_W-1:0]          rsp_addr,
   output logic [REGION_LOG2-SLOT_LOG2-1:0] rsp_slot
);
   import adec_pkg::*;

   localparam int BASE_W = ADDR_W - BANK_LOG2;
   localparam int OFF_W  = BANK_LOG2 - UNIT_LOG2;
   localparam int SLOT_W = REGION_LOG2 - SLOT_LOG2;
   localparam int HI_W   = ADDR_W - REGION_LOG2;

   // elaboration-time parameter checks
   if (NCS < 1)                     begin : g_bad_ncs   $error("NCS must be at least 1");          end
   if (NCS > (1 << BASE_W))         begin : g_bad_ncs2  $error("NCS exceeds base field range");    end
   if (BANK_LOG2 <= UNIT_LOG2)      begin : g_bad_unit  $error("bank must exceed size unit");      end
   if (REGION_LOG2 >= BANK_LOG2)    begin : g_bad_rgn   $error("edge region must be below bank");  end
   if (SLOT_LOG2 >= REGION_LOG2)    begin : g_bad_slot  $error("slot must fit peripheral region"); end
   if (INTC_LOG2 > SLOT_LOG2)       begin : g_bad_intc  $error("intc window exceeds slot");        end
   if (ALIGN_LOG2 > INTC_LOG2)      begin : g_bad_align $error("alignment exceeds intc window");   end
   if (BANK_LOG2 >= ADDR_W)         begin : g_bad_addr  $error("bank exceeds address width");      end

   // remap flag
   logic remap_q;
   adec_remap_reg u_remap (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (remap_req),
      .flag_q  (remap_q)
   );

   // region classification
   logic is_low, is_high, is_window;
   adec_region_sort #(.ADDR_W(ADDR_W), .REGION_LOG2(REGION_LOG2)) u_sort (
      .addr_hi   (req_addr[ADDR_W-1:REGION_LOG2]),
      .is_low    (is_low),
      .is_high   (is_high),
      .is_window (is_window)
   );

   // per-bank match and gating
   logic [NCS-1:0] bank_hit;
   logic [NCS-1:0] bank_usable;
   logic [NCS-1:0] bank_req;
   logic [NCS-1:0] bank_gnt;

   for (genvar b = 0; b < NCS; b++) begin : g_bank
      adec_bank_match #(.BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_match (
         .addr_base (req_addr[ADDR_W-1:BANK_LOG2]),
         .addr_off  (req_addr[BANK_LOG2-1:UNIT_LOG2]),
         .cfg_base  (cfg_bank_base[b*BASE_W +: BASE_W]),
         .cfg_size  (cfg_bank_size[b*SIZE_W +: SIZE_W]),
         .cfg_en    (cfg_bank_en[b]),
         .hit       (bank_hit[b])
      );
      if (b == 0) begin : g_boot
         assign bank_usable[b] = 1'b1;
      end else begin : g_gated
         assign bank_usable[b] = remap_q;
      end
   end

   assign bank_req = bank_hit & bank_usable;

   adec_pick_first #(.N(NCS)) u_pick (
      .req (bank_req),
      .gnt (bank_gnt)
   );

   // next-state decode
   region_e             nx_region;
   logic [NCS-1:0]      nx_cs;
   logic                nx_abort;
   logic [ADDR_W-1:0]   nx_addr;
   logic [SLOT_W-1:0]   nx_slot;
   logic [SLOT_W-1:0]   addr_slot;
   logic [HI_W-1:0]     unused_hi;

   assign addr_slot = req_addr[REGION_LOG2-1:SLOT_LOG2];
   assign unused_hi = '0;

   always_comb begin
      nx_region = RGN_NONE;
      nx_cs     = '0;
      nx_abort  = 1'b0;
      nx_addr   = req_addr;
      nx_slot   = '0;
      if (req_valid) begin
         if (is_high) begin
            nx_region = RGN_PERIPH;
            nx_slot   = addr_slot;
            nx_addr[ALIGN_LOG2-1:0] = '0;
            if (addr_slot == '1) begin
               nx_addr[SLOT_LOG2-1:INTC_LOG2] = '0;
            end
         end else if (is_low) begin
            if (remap_q) begin
               nx_region = RGN_IRAM;
            end else begin
               nx_region = RGN_EXT;
               nx_cs[0]  = 1'b1;
            end
         end else if (is_window) begin
            nx_region = RGN_EXT;
            nx_cs     = bank_gnt;
            nx_abort  = (bank_req == '0);
         end
      end
   end

   // registered response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_region <= RGN_NONE;
         rsp_cs     <= '0;
         rsp_abort  <= 1'b0;
         rsp_addr   <= '0;
         rsp_slot   <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_region <= nx_region;
         rsp_cs     <= nx_cs;
         rsp_abort  <= nx_abort;
         rsp_addr   <= req_valid ? nx_addr : '0;
         rsp_slot   <= nx_slot;
      end
   end

   assign remap_active = remap_q | (|unused_hi);
endmodule

// File: rtl/adec_checker.sv
module adec_checker #(
   parameter int ADDR_W = 32,
   parameter int NCS    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              remap_active,
   input logic              rsp_valid,
   input logic [2:0]        rsp_region,
   input logic [NCS-1:0]    rsp_cs,
   input logic              rsp_abort,
   input logic [ADDR_W-1:0] rsp_addr
);
   p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_cs));

   p_one_region_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones(rsp_region) == 1);

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_region == 3'b000 && rsp_cs == '0 && !rsp_abort));

   p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_abort_nocs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_abort |-> (rsp_cs == '0 && rsp_region == 3'b010));

   p_periph_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_region == 3'b100) |-> (rsp_addr[1:0] == 2'b00 && rsp_cs == '0 && !rsp_abort));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      remap_active |=> remap_active);

   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(remap_active)) |-> ((rsp_cs >> 1) == '0));

   p_iram_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_region == 3'b001) |-> $past(remap_active));
endmodule

bind addr_region_decoder adec_checker #(.ADDR_W(ADDR_W), .NCS(NCS)) u_adec_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .remap_active (remap_active),
   .rsp_valid    (rsp_valid),
   .rsp_region   (rsp_region),
   .rsp_cs       (rsp_cs),
   .rsp_abort    (rsp_abort),
   .rsp_addr     (rsp_addr)
);

// File: tb/test_addr_region_decoder.sv
module test_addr_region_decoder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        remap_req = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  cfg_bank_en = '0;
   logic [63:0] cfg_bank_base;
   logic [23:0] cfg_bank_size;
   logic        remap_active;
   logic        rsp_valid;
   logic [2:0]  rsp_region;
   logic [7:0]  rsp_cs;
   logic        rsp_abort;
   logic [31:0] rsp_addr;
   logic [7:0]  rsp_slot;

   logic [7:0]  bb [8];
   logic [2:0]  bs [8];
   logic        model_remap = 1'b0;
   int          checks = 0;
   int          fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < 8; i++) begin
         cfg_bank_base[i*8 +: 8] = bb[i];
         cfg_bank_size[i*3 +: 3] = bs[i];
      end
   end

   addr_region_decoder i_addr_region_decoder (
      .clk(clk), .rst_n(rst_n), .remap_req(remap_req), .req_valid(req_valid),
      .req_addr(req_addr), .cfg_bank_en(cfg_bank_en), .cfg_bank_base(cfg_bank_base),
      .cfg_bank_size(cfg_bank_size), .remap_active(remap_active), .rsp_valid(rsp_valid),
      .rsp_region(rsp_region), .rsp_cs(rsp_cs), .rsp_abort(rsp_abort),
      .rsp_addr(rsp_addr), .rsp_slot(rsp_slot)
   );

   // reference model built from the requirements
   task automatic ref_decode(input logic [31:0] a, input logic rm,
                             output logic [2:0] er, output logic [7:0] ec,
                             output logic ea, output logic [31:0] eo,
                             output logic [7:0] es);
      er = 3'b000; ec = '0; ea = 1'b0; eo = a; es = '0;
      if (a[31:22] == 10'h3FF) begin                    // R4, R5
         er = 3'b100; es = a[21:14]; eo[1:0] = 2'b00;
         if (a[21:14] == 8'hFF) eo[13:12] = 2'b00;
      end else if (a[31:22] == 10'h000) begin           // R2, R3
         if (rm) er = 3'b001;
         else begin er = 3'b010; ec = 8'h01; end
      end else begin                                    // R6, R7, R8, R10
         logic found;
         found = 1'b0;
         er = 3'b010;
         for (int i = 0; i < 8; i++) begin
            if (!found && cfg_bank_en[i] && a[31:24] == bb[i] &&
                (bs[i] >= 3'd4 || (a[23:20] >> bs[i]) == 4'd0) &&
                (i == 0 || rm)) begin
               found = 1'b1; ec[i] = 1'b1;
            end
         end
         ea = !found;
      end
   endtask

   task automatic issue(input logic [31:0] a, input logic rr, input string tag);
      logic [2:0] er; logic [7:0] ec; logic ea; logic [31:0] eo; logic [7:0] es;
      ref_decode(a, model_remap, er, ec, ea, eo, es);
      req_valid = 1'b1; req_addr = a; remap_req = rr;
      @(negedge clk);
      model_remap = model_remap | rr;
      req_valid = 1'b0; remap_req = 1'b0;
      checks++;
      if (rsp_valid !== 1'b1 || rsp_region !== er || rsp_cs !== ec || rsp_abort !== ea ||
          rsp_addr !== eo || rsp_slot !== es || remap_active !== model_remap) begin
         fails++;
         $display("FAIL %s addr=%h: got v=%b rgn=%b cs=%b ab=%b a=%h s=%h rm=%b exp v=1 rgn=%b cs=%b ab=%b a=%h s=%h rm=%b",
                  tag, a, rsp_valid, rsp_region, rsp_cs, rsp_abort, rsp_addr, rsp_slot,
                  remap_active, er, ec, ea, eo, es, model_remap);
      end
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_region !== 3'b000 || rsp_cs !== 8'h00 ||
          rsp_abort !== 1'b0 || remap_active !== model_remap) begin
         fails++;
         $display("FAIL %s idle: got v=%b rgn=%b cs=%b ab=%b rm=%b exp v=0 rgn=000 cs=00 ab=0 rm=%b",
                  tag, rsp_valid, rsp_region, rsp_cs, rsp_abort, remap_active, model_remap);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_remap = 1'b0;
      repeat (3) @(negedge clk);
      checks++;   // R1: reset state
      if (rsp_valid !== 1'b0 || rsp_region !== 3'b000 || rsp_cs !== 8'h00 || rsp_abort !== 1'b0 ||
          rsp_addr !== 32'h0 || rsp_slot !== 8'h00 || remap_active !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: got v=%b rgn=%b cs=%b ab=%b a=%h s=%h rm=%b exp all zero",
                  rsp_valid, rsp_region, rsp_cs, rsp_abort, rsp_addr, rsp_slot, remap_active);
      end
      rst_n = 1'b1;
      idle_check("R1");
   endtask

   function automatic logic [31:0] rand_addr(output string tag);
      logic [31:0] a;
      int k;
      k = $urandom_range(0, 5);
      a = $urandom;
      case (k)
         0: begin a[31:22] = 10'h000; tag = "R2/R3"; end
         1: begin a[31:22] = 10'h3FF; tag = "R4"; end
         2: begin a[31:14] = 18'h3FFFF; tag = "R5"; end
         3, 4: begin a[31:24] = bb[$urandom_range(0, 7)]; tag = "R6/R10"; end
         default: tag = "R8";
      endcase
      return a;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, exp completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      bb[0] = 8'h10; bs[0] = 3'd4;
      bb[1] = 8'h20; bs[1] = 3'd1;
      bb[2] = 8'h30; bs[2] = 3'd2;
      bb[3] = 8'h30; bs[3] = 3'd7;   // overlaps bank 2, wider
      bb[4] = 8'h40; bs[4] = 3'd0;
      bb[5] = 8'h10; bs[5] = 3'd4;   // overlaps bank 0
      bb[6] = 8'h60; bs[6] = 3'd3;
      bb[7] = 8'h70; bs[7] = 3'd4;
      cfg_bank_en = 8'b0111_1111;    // bank 7 disabled
      do_reset();

      // pre-remap directed
      issue(32'h0000_0100, 1'b0, "R3");
      issue(32'h003F_FFFF, 1'b0, "R3");
      issue(32'h100F_0004, 1'b0, "R7");      // bank 0 usable before remap
      issue(32'h2000_0000, 1'b0, "R7");      // bank 1 gated -> abort
      issue(32'h8000_0000, 1'b0, "R8");
      issue(32'hFFC0_0003, 1'b0, "R4");
      issue(32'hFFFF_F7FF, 1'b0, "R5");
      issue(32'hFFFF_3001, 1'b0, "R5");
      idle_check("R11");
      // remap in same cycle as low access: old mapping used
      issue(32'h0000_0040, 1'b1, "R13");
      issue(32'h0000_0040, 1'b0, "R2");
      issue(32'h0000_0044, 1'b1, "R9");      // second request no effect
      // post-remap directed
      issue(32'h2010_0000, 1'b0, "R10");     // code 1: 2 MB, offset 1 MB in
      issue(32'h2020_0000, 1'b0, "R10");     // outside 2 MB -> abort
      issue(32'h3030_0000, 1'b0, "R6");      // bank 2 (4 MB) wins over 3
      issue(32'h3050_0000, 1'b0, "R6");      // beyond bank 2, bank 3 covers
      issue(32'h4010_0000, 1'b0, "R10");     // code 0: 1 MB -> abort
      issue(32'h10AB_CDEF, 1'b0, "R6");      // bank 0 over bank 5
      issue(32'h7000_0000, 1'b0, "R8");      // disabled bank 7
      issue(32'h1234_5679, 1'b0, "R12");
      idle_check("R11");

      for (int n = 0; n < 300; n++) begin
         string tag;
         logic [31:0] a;
         a = rand_addr(tag);
         issue(a, 1'b0, tag);
         if ($urandom_range(0, 7) == 0) idle_check("R11");
      end

      // R9: only reset clears remap
      do_reset();
      issue(32'h0000_0000, 1'b0, "R9");
      for (int n = 0; n < 150; n++) begin
         string tag;
         logic [31:0] a;
         a = rand_addr(tag);
         issue(a, (n == 75), tag);
      end
      finish_run();
   end
endmodule